// File: doc/BRIEF.md
# Dual carry-less 16x64 multiply-accumulate unit

This unit forms two carry-less (GF(2)) products at once and returns their XOR. Each product multiplies a 16-bit coefficient by a 64-bit data word, so the result is 80 bits wide. It is the basic step of a polynomial fold: a running remainder is multiplied by a precomputed constant and then merged with fresh data.

The datapath has no wide multiplier. Every operand is split into bytes, with byte 0 as the least significant. Each byte pair is multiplied by an 8x8 carry-less multiplier that gives a 16-bit product. Products whose byte indices add up to the same rank k are XORed together, and the two independent products are merged at this point too. Each rank sum is then shifted left by 8*k bits and folded into the result.

By default the result and a valid flag are registered, giving a fixed latency of one cycle. A parameter selects a purely combinational variant instead.

Top module: `clmul_dual16x64`

## Requirements
- R1: With `valid_in` high, the `result` seen one cycle later equals clmul(`coef_a`,`data_a`) XOR clmul(`coef_b`,`data_b`). Here clmul is the 80-bit polynomial product over GF(2), and bit i of each operand is the coefficient of x^i.
- R2: `valid_out` equals `valid_in` delayed by exactly one clock cycle.
- R3: While `valid_in` is low, `result` keeps its last value, whatever happens on the operand inputs.
- R4: While `rst_n` is low, `valid_out` is 0 and `result` is all zeros.
- R5: If both coefficients are zero, or both data words are zero, the result is all zeros.
- R6: With `coef_a` = 1 and `coef_b` = 0, the result is `data_a` zero-extended to 80 bits.
- R7: Bits 79..72 can be nonzero only through rank 8, which is the high coefficient byte times data byte 7. If both high coefficient bytes are zero, bits 79..72 are zero.
- R8: Swapping the (coef_a, data_a) pair with the (coef_b, data_b) pair leaves the result unchanged. Presenting the same pair on both sides gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands are valid this cycle |
| coef_a | input | 16 | First 16-bit coefficient |
| data_a | input | 64 | First 64-bit data word |
| coef_b | input | 16 | Second 16-bit coefficient |
| data_b | input | 64 | Second 64-bit data word |
| valid_out | output | 1 | Result is valid |
| result | output | 80 | XOR of the two carry-less products |

## Verification
Each result is compared with a shift-and-XOR model that walks the coefficient bit by bit.

Walking single bits in the coefficient and the data word test every rank shift in isolation. A single-bit error then points to one byte pair and one rank. All-ones operands and a pseudo-random sweep exercise the rank grouping and the XOR merge of ranks with mixed contributions. The identity and zero coefficients, the top-byte case and the swapped-pair case test the pass-through behaviour, the rank 8 path and the symmetry of the two products. Changing the operands while `valid_in` is low shows whether the output register loads when it should not.

// File: rtl/clmul_dual16x64.sv
module clmul_dual16x64 #(
  parameter int DATA_BYTES = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_in,
  input  logic [15:0]                 coef_a,
  input  logic [8*DATA_BYTES-1:0]     data_a,
  input  logic [15:0]                 coef_b,
  input  logic [8*DATA_BYTES-1:0]     data_b,
  output logic                        valid_out,
  output logic [8*DATA_BYTES+15:0]    result
);
  localparam int COEF_W = 16;
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int RES_W  = DATA_W + COEF_W;
  localparam int RANKS  = DATA_BYTES + 1;

  function automatic logic [15:0] clmul8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++)
      if (b[i]) p = p ^ ({8'b0, a} << i);
    return p;
  endfunction

  logic [15:0]      rank_sum [RANKS];
  logic [RES_W-1:0] acc;

  genvar k;
  generate
    for (k = 0; k < RANKS; k++) begin : g_rank
      logic [15:0] lo_part, hi_part;
      if (k < DATA_BYTES) begin : g_lo
        assign lo_part = clmul8(coef_a[7:0], data_a[8*k +: 8])
                       ^ clmul8(coef_b[7:0], data_b[8*k +: 8]);
      end else begin : g_lo_none
        assign lo_part = '0;
      end
      if (k > 0) begin : g_hi
        assign hi_part = clmul8(coef_a[15:8], data_a[8*(k-1) +: 8])
                       ^ clmul8(coef_b[15:8], data_b[8*(k-1) +: 8]);
      end else begin : g_hi_none
        assign hi_part = '0;
      end
      assign rank_sum[k] = lo_part ^ hi_part;
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int r = 0; r < RANKS; r++)
      acc = acc ^ (RES_W'(rank_sum[r]) << (8 * r));
  end

  generate
    if (REGISTERED) begin : g_reg
      logic             vld_q;
      logic [RES_W-1:0] res_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
        end else begin
          vld_q <= valid_in;
          if (valid_in) res_q <= acc;
        end
      end

      assign valid_out = vld_q;
      assign result    = res_q;

      a_r2_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
      a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
      a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(result));
      a_r5_zero_coefs: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && coef_a == '0 && coef_b == '0) |=> (result == '0));
      a_r6_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && coef_a == 16'd1 && coef_b == '0) |=> (result == {16'b0, $past(data_a)}));
      a_r7_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && coef_a[15:8] == '0 && coef_b[15:8] == '0) |=> (result[RES_W-1 -: 8] == '0));
    end else begin : g_comb
      assign valid_out = valid_in;
      assign result    = acc;

      always_comb begin
        if (coef_a == '0 && coef_b == '0)
          a_r5_zero_comb: assert (result == '0);
      end
    end
  endgenerate
endmodule

// File: tb/tb_clmul_dual16x64.sv
module tb_clmul_dual16x64;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [15:0] coef_a = '0, coef_b = '0;
  logic [63:0] data_a = '0, data_b = '0;
  logic        valid_out;
  logic [79:0] result;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clmul_dual16x64 dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .coef_a(coef_a), .data_a(data_a), .coef_b(coef_b), .data_b(data_b),
    .valid_out(valid_out), .result(result)
  );

  function automatic logic [79:0] ref_clmul(input logic [15:0] w, input logic [63:0] x);
    logic [79:0] r;
    r = '0;
    for (int i = 0; i < 16; i++)
      if (w[i]) r = r ^ ({16'b0, x} << i);
    return r;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] wa, input logic [63:0] xa,
                       input logic [15:0] wb, input logic [63:0] xb);
    coef_a = wa; data_a = xa; coef_b = wb; data_b = xb;
    valid_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_and_check(input string req, input logic [15:0] wa, input logic [63:0] xa,
                               input logic [15:0] wb, input logic [63:0] xb);
    apply(wa, xa, wb, xb);
    check(req, result, ref_clmul(wa, xa) ^ ref_clmul(wb, xb));
    check("R2", {79'b0, valid_out}, 80'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    valid_in = 1'b1;
    coef_a = 16'hFFFF; data_a = '1;
    repeat (3) @(negedge clk);
    check("R4 result", result, '0);
    check("R4 valid", {79'b0, valid_out}, '0);
    valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_zero();
    run_and_check("R5 zero coefs", 16'h0, 64'hDEADBEEF_01234567, 16'h0, 64'hFFFF_0000_FFFF_0000);
    check("R5 zero coefs value", result, '0);
    run_and_check("R5 zero data", 16'hBEEF, 64'h0, 16'h1234, 64'h0);
    check("R5 zero data value", result, '0);
  endtask

  task automatic t_identity();
    run_and_check("R6", 16'h0001, 64'hA5C3_0F1E_7788_9911, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 passthrough", result, {16'b0, 64'hA5C3_0F1E_7788_9911});
  endtask

  task automatic t_top_rank();
    run_and_check("R7 rank8", 16'h8000, 64'h8000_0000_0000_0000, 16'h0, 64'h0);
    check("R7 top bit", result, 80'h1 << 78);
    run_and_check("R7 low bytes only", 16'h00FF, '1, 16'h00FF, 64'h0123_4567_89AB_CDEF);
    check("R7 top byte zero", {72'b0, result[79:72]}, '0);
  endtask

  task automatic t_walk();
    for (int i = 0; i < 16; i++)
      run_and_check("R1 walk coef", 16'(1) << i, 64'h8000_0000_0000_0001, 16'h0, 64'h0);
    for (int j = 0; j < 64; j += 7)
      run_and_check("R1 walk data", 16'h8421, 64'(1) << j, 16'h0101, 64'(1) << (63 - j));
    run_and_check("R1 all ones", 16'hFFFF, '1, 16'hFFFF, 64'h5555_5555_5555_5555);
  endtask

  task automatic t_random();
    logic [63:0] s;
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 40; n++) begin
      logic [15:0] wa, wb;
      logic [63:0] xa, xb;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); xa = s; wa = s[47:32];
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); xb = s; wb = s[31:16];
      run_and_check("R1 random", wa, xa, wb, xb);
    end
  endtask

  task automatic t_swap();
    logic [79:0] first;
    run_and_check("R8 order1", 16'h1357, 64'h0F0F_1234_ABCD_8001, 16'hC0DE, 64'h7654_3210_FEDC_BA98);
    first = result;
    run_and_check("R8 order2", 16'hC0DE, 64'h7654_3210_FEDC_BA98, 16'h1357, 64'h0F0F_1234_ABCD_8001);
    check("R8 swap equal", result, first);
    run_and_check("R8 self cancel", 16'hABCD, 64'h1122_3344_5566_7788, 16'hABCD, 64'h1122_3344_5566_7788);
    check("R8 cancel zero", result, '0);
  endtask

  task automatic t_hold();
    logic [79:0] held;
    run_and_check("R3 load", 16'h00F1, 64'h0000_0000_DEAD_0001, 16'h0, 64'h0);
    held = result;
    valid_in = 1'b0;
    coef_a = 16'hFFFF; data_a = '1; coef_b = 16'h1234; data_b = 64'h55AA;
    @(negedge clk);
    check("R3 hold", result, held);
    check("R2 drop", {79'b0, valid_out}, '0);
    coef_a = 16'h0001; data_a = 64'h0;
    @(negedge clk);
    check("R3 hold2", result, held);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_zero();
    t_identity();
    t_top_rank();
    t_walk();
    t_random();
    t_swap();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule